// File: doc/BRIEF.md
# Cascadable TDM Stereo Slot Shifter

This block is the serial output slot of a stereo audio sample-rate stage. Each stage holds one 64-bit word. When frame sync is high at a bit-clock rising edge, the stage loads its left and right samples into that word. On every other rising edge it shifts the word one place toward its serial output and takes one bit from an upstream stage at the far end.

The top module joins `STAGES` such stages output to input, so they act as one shift register of `STAGES`×64 bits. That register presents a single TDM frame on one serial line to a host serial port. All stages share the bit clock and the frame sync. The stage nearest the host, index `STAGES-1`, sends its own word first. The words of the stages farther up the chain follow in order, and after them the bits that arrive on the chain input. The bit clock must satisfy `STAGES × 64 × frame_rate ≤ f_bitclk_max`.

Top module: `tdm_slot_chain`

## Requirements
- R1: An active-high synchronous reset clears every stage to zero. After reset, with `chain_in` held low and no frame sync, `chain_out` is 0 and stays 0 for `STAGES`×64 bit clocks.
- R2: When `fsync` is high at a rising edge of `clk`, every stage loads its sample pair. Right after that edge, `chain_out` equals bit 31 of the left sample of stage `STAGES-1`.
- R3: In each 64-bit word, the left sample occupies bits [63:32] and the right sample bits [31:0], and the word leaves MSB first. The first 64 bits after a load are therefore left bit 31 down to bit 0, then right bit 31 down to bit 0.
- R4: The frame on `chain_out` carries the stage words in the order `STAGES-1`, `STAGES-2`, …, 0, for `STAGES`×64 bits in total.
- R5: The value sampled on `chain_in` at the (1+m)-th rising edge after the load edge appears on `chain_out` right after the (`STAGES`×64+m)-th edge after the load edge.
- R6: When `fsync` is high on consecutive edges, the load wins over the shift at each of them. The frame then carries the data loaded at the last of those edges.
- R7: When reset and frame sync are both high at an edge, reset wins and every stage is cleared.
- R8: A frame sync partway through a frame drops the bits not yet sent and restarts the frame with the newly loaded data.
- R9: `chain_out` is a registered output that changes only at rising edges of `clk`. Each shift moves the bit below the MSB into the output position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared serial bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; high at an edge loads all stages |
| chain_in | input | 1 | Serial data from an upstream chain (far end) |
| left_in | input | STAGES*SAMPLE_W | Left samples; stage s uses bits [s*SAMPLE_W +: SAMPLE_W] |
| right_in | input | STAGES*SAMPLE_W | Right samples; stage s uses bits [s*SAMPLE_W +: SAMPLE_W] |
| chain_out | output | 1 | Serial TDM frame toward the host |

## Verification
The bench records whole frames and compares the head bit, the nearest stage's word, the farther stages' words and the trailing chain-input bits against its own model. A design that swapped left and right, sent LSB first or reversed the stage order fails the word and stage comparisons. A one-cycle slip in the chain link fails the tail comparison. The bench also holds frame sync high over two edges, restarts a frame partway through, and asserts reset together with frame sync. A shift that beat the load, a stale remainder of the old frame, or a load that beat reset would each leave wrong or nonzero bits on the line.

// File: rtl/tdm_chain_pkg.sv
`timescale 1ns/1ps
package tdm_chain_pkg;

  // Per-edge action of one stage's slot register
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } slot_op_e;

  // Samples packed into one slot word (left, then right)
  localparam int SAMPLES_PER_WORD = 2;

  // Priority: reset, then frame-sync load, then shift
  function automatic slot_op_e pick_op(input logic rst, input logic fsync);
    if (rst)        return OP_CLEAR;
    else if (fsync) return OP_LOAD;
    else            return OP_SHIFT;
  endfunction

  // Width of one stage's slot word
  function automatic int word_bits(input int sample_w);
    return SAMPLES_PER_WORD * sample_w;
  endfunction

  // Length of the TDM frame produced by a chain of stages
  function automatic int frame_bits(input int stages, input int sample_w);
    return stages * word_bits(sample_w);
  endfunction

endpackage

// File: rtl/slot_ctrl.sv
`timescale 1ns/1ps
module slot_ctrl
  import tdm_chain_pkg::*;
(
  input  logic     rst,
  input  logic     fsync,
  output slot_op_e op,
  output logic     clr_evt,
  output logic     load_evt,
  output logic     shift_evt
);

  always_comb begin
    op        = pick_op(rst, fsync);
    clr_evt   = (op == OP_CLEAR);
    load_evt  = (op == OP_LOAD);
    shift_evt = (op == OP_SHIFT);
  end

endmodule

// File: rtl/slot_reg.sv
`timescale 1ns/1ps
module slot_reg #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_evt,
  input  logic              load_evt,
  input  logic              shift_evt,
  input  logic [WORD_W-1:0] par_d,
  input  logic              ser_i,
  output logic              ser_o
);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (clr_evt)        word_q <= '0;
    else if (load_evt)  word_q <= par_d;
    else if (shift_evt) word_q <= {word_q[WORD_W-2:0], ser_i};
  end

  assign ser_o = word_q[WORD_W-1];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (word_q == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (word_q == $past(par_d)));

  // R5
  shift_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (word_q[0] == $past(ser_i)));

  // R9
  shift_out_chk: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (ser_o == $past(word_q[WORD_W-2])));

endmodule

// File: rtl/slot_stage.sv
`timescale 1ns/1ps
module slot_stage
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fsync,
  input  logic [SAMPLE_W-1:0] left_d,
  input  logic [SAMPLE_W-1:0] right_d,
  input  logic                ser_i,
  output logic                ser_o
);

  localparam int WORD_W = word_bits(SAMPLE_W);

  // Left sample in the upper half, right sample in the lower half
  function automatic logic [WORD_W-1:0] pack_pair(
    input logic [SAMPLE_W-1:0] l,
    input logic [SAMPLE_W-1:0] r
  );
    return {l, r};
  endfunction

  slot_op_e          op;
  logic              clr_evt;
  logic              load_evt;
  logic              shift_evt;
  logic [WORD_W-1:0] pair_word;

  assign pair_word = pack_pair(left_d, right_d);

  slot_ctrl u_ctrl (
    .rst       (rst),
    .fsync     (fsync),
    .op        (op),
    .clr_evt   (clr_evt),
    .load_evt  (load_evt),
    .shift_evt (shift_evt)
  );

  slot_reg #(.WORD_W(WORD_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .clr_evt   (clr_evt),
    .load_evt  (load_evt),
    .shift_evt (shift_evt),
    .par_d     (pair_word),
    .ser_i     (ser_i),
    .ser_o     (ser_o)
  );

  // R7
  reset_priority_chk: assert property (@(posedge clk)
    rst |-> (op == OP_CLEAR && !load_evt));

  // R6
  load_priority_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> (ser_o == $past(left_d[SAMPLE_W-1])));

endmodule

// File: rtl/tdm_slot_chain.sv
`timescale 1ns/1ps
module tdm_slot_chain
  import tdm_chain_pkg::*;
#(
  parameter int STAGES   = 4,
  parameter int SAMPLE_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fsync,
  input  logic                         chain_in,
  input  logic [STAGES*SAMPLE_W-1:0]   left_in,
  input  logic [STAGES*SAMPLE_W-1:0]   right_in,
  output logic                         chain_out
);

  // link[0] is the far end, link[STAGES] faces the host
  logic [STAGES:0] link;

  assign link[0]   = chain_in;
  assign chain_out = link[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    slot_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .fsync   (fsync),
      .left_d  (left_in[s*SAMPLE_W +: SAMPLE_W]),
      .right_d (right_in[s*SAMPLE_W +: SAMPLE_W]),
      .ser_i   (link[s]),
      .ser_o   (link[s+1])
    );
  end

  // R2
  head_bit_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> (chain_out == $past(left_in[STAGES*SAMPLE_W-1])));

endmodule

// File: tb/sim_tdm_slot_chain.sv
`timescale 1ns/1ps
module sim_tdm_slot_chain;

  localparam int N    = 4;
  localparam int SW   = 32;
  localparam int WW   = 2 * SW;
  localparam int TOT  = N * WW;
  localparam int TAIL = 16;
  localparam int NV   = 4;

  localparam logic [31:0] SEED_T [NV] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_00FF, 32'h8000_0001};
  localparam logic [31:0] CIN_T  [NV] = '{32'h0000_A5C3, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_8E71};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsync = 1'b0;
  logic chain_in = 1'b0;
  logic [N*SW-1:0] left_in  = '0;
  logic [N*SW-1:0] right_in = '0;
  logic chain_out;

  always #10 clk = ~clk;

  tdm_slot_chain #(.STAGES(N), .SAMPLE_W(SW)) u0 (
    .clk(clk), .rst(rst), .fsync(fsync), .chain_in(chain_in),
    .left_in(left_in), .right_in(right_in), .chain_out(chain_out)
  );

  int checks = 0;
  int fails  = 0;
  logic got [TOT+TAIL];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] mk_left(input logic [31:0] seed, input int s);
    return seed + 32'h0111_0011 * s;
  endfunction

  function automatic logic [SW-1:0] mk_right(input logic [31:0] seed, input int s);
    return {seed[15:0], seed[31:16]} ^ (32'hA5A5_0000 + s);
  endfunction

  // Expected frame bit j: stage N-1 first, each left MSB-first then right MSB-first
  function automatic logic exp_bit(input logic [31:0] seed, input int j);
    int s, b;
    logic [SW-1:0] l, r;
    s = N - 1 - j / WW;
    b = j % WW;
    l = mk_left(seed, s);
    r = mk_right(seed, s);
    if (b < SW) return l[SW-1-b];
    return r[SW-1-(b-SW)];
  endfunction

  task automatic set_data(input logic [31:0] seed);
    for (int s = 0; s < N; s++) begin
      left_in[s*SW +: SW]  = mk_left(seed, s);
      right_in[s*SW +: SW] = mk_right(seed, s);
    end
  endtask

  // Called at a negedge right after the load edge; records the frame and tail
  task automatic capture(input logic [31:0] cseed);
    got[0] = chain_out;
    for (int j = 1; j < TOT + TAIL; j++) begin
      chain_in = (j - 1 < TAIL) ? cseed[j-1] : 1'b0;
      @(posedge clk);
      @(negedge clk);
      got[j] = chain_out;
    end
    chain_in = 1'b0;
  endtask

  task automatic cmp_frame(input logic [31:0] seed, input int lo, input int hi,
                           input string req, input string what);
    int bad = 0;
    int first = -1;
    for (int j = lo; j < hi; j++)
      if (got[j] !== exp_bit(seed, j)) begin
        bad++;
        if (first < 0) first = j;
      end
    if (bad == 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, $sformatf("%s first bad bit %0d", what, first),
               64'(got[first]), 64'(exp_bit(seed, first)));
  endtask

  task automatic load_at_edge(input logic [31:0] seed);
    set_data(seed);
    fsync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic expect_zero_run(input string req, input string what);
    int ones = 0;
    if (chain_out !== 1'b0) ones++;
    for (int j = 0; j < TOT; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (chain_out !== 1'b0) ones++;
    end
    check(ones == 0, req, what, 64'(ones), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(chain_out === 1'b0, "R1", "output after reset", 64'(chain_out), 0);
    expect_zero_run("R1", "nonzero bits after reset");

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      load_at_edge(SEED_T[v]);
      capture(CIN_T[v]);
      check(got[0] === exp_bit(SEED_T[v], 0), "R2", "head bit after load",
            64'(got[0]), 64'(exp_bit(SEED_T[v], 0)));
      cmp_frame(SEED_T[v], 1, WW, "R3", "nearest stage word");
      cmp_frame(SEED_T[v], WW, TOT, "R4", "farther stage words");
      begin
        int bad = 0;
        int first = -1;
        for (int m = 0; m < TAIL; m++)
          if (got[TOT+m] !== CIN_T[v][m]) begin
            bad++;
            if (first < 0) first = m;
          end
        if (bad == 0) check(1'b1, "R5", "chain input tail", 0, 0);
        else check(1'b0, "R5", $sformatf("chain input tail bit %0d", first),
                   64'(got[TOT+first]), 64'(CIN_T[v][first]));
      end
    end

    // R6: frame sync on two consecutive edges, new data at the second
    set_data(32'hCAFE_0123);
    fsync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    set_data(32'h5A5A_7E7E);
    @(posedge clk);
    @(negedge clk);
    fsync = 1'b0;
    capture(32'h0);
    cmp_frame(32'h5A5A_7E7E, 0, TOT, "R6", "frame after held frame sync");

    // R8: restart partway through a frame
    load_at_edge(32'h1357_9BDF);
    repeat (100) begin
      @(posedge clk);
      @(negedge clk);
    end
    load_at_edge(32'h2468_ACE0);
    capture(32'h0);
    cmp_frame(32'h2468_ACE0, 0, TOT, "R8", "frame after mid-frame restart");

    // R7: reset and frame sync at the same edge
    load_at_edge(32'hFFFF_FFFF);
    set_data(32'hFFFF_FFFF);
    rst = 1'b1;
    fsync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fsync = 1'b0;
    expect_zero_run("R7", "nonzero bits after reset with frame sync");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule